// File: doc/BRIEF.md
# Double-Buffered Scan Line Pixel Store

This block keeps the pixel pattern for one raster line of a laser writer, at one bit per pixel, in two equal banks. At any moment one bank is the active line and the other is the back buffer. A scan sequencer reads the active line with a pixel index and gets one pixel per cycle. A command decoder fills the back buffer one 16-bit word at a time. It uses a store strobe to write a word at the current word pointer and a separate step strobe to move the pointer forward.

When a new line is complete, the decoder issues a load strobe. The banks then trade roles at the next clock edge. No pixels are copied, so the read side never stalls, however slowly the back buffer was filled. The bank that was active becomes the new back buffer and keeps its old contents until they are overwritten. The line length and word width are parameters. The defaults are 2048 pixels in 128 words of 16 bits.

Top module: `scanline_dbuf`

## Requirements
- R1: While `rst_n` is low, `pix_out` is 0, and the output goes to 0 as soon as reset is asserted, without waiting for a clock edge. After reset the back-buffer word pointer is 0.
- R2: Pixel index n (0..2047) selects bit (n mod 16) of active-line word n/16. Bit 0 is the first pixel of a word.
- R3: `pix_out` is registered. It shows the pixel for the index that was present at the previous rising edge and holds until the next edge.
- R4: A store writes `wr_data` into the back-buffer word at the current pointer. The active line is unchanged and `pix_out` is unaffected until a load.
- R5: A step advances the word pointer by one word (16 pixels) and wraps from 127 to 0. When store and step occur in the same cycle, the word is written at the old pointer and then the pointer advances.
- R6: A load makes the back buffer the active line from the next edge on. The former active line becomes the back buffer and keeps its contents. A load resets the word pointer to 0, and this takes priority over a step in the same cycle.
- R7: A store and a load in the same cycle write the word first, so the new active line includes it.
- R8: A read in the same cycle as a load returns the pixel from the line that was active before the load. Back-buffer writes never change the pixels read from the active line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; takes effect at once and is released on a clock edge |
| wr_data | input | 16 | Data word for a store |
| wr_store | input | 1 | Store strobe: write `wr_data` at the word pointer |
| wr_next | input | 1 | Step strobe: advance the word pointer by one |
| line_load | input | 1 | Load strobe: swap the back buffer into the active line |
| pix_idx | input | 11 | Pixel index into the active line |
| pix_out | output | 1 | Registered pixel value |

## Verification
Some checks run on every cycle. The word pointer must step, wrap, hold, or return to zero on a load. The bank roles must flip only on a load. No more than one bank may be written per cycle. `pix_out` must stay steady while the index holds and no swap has taken place.

Other behaviour can only be shown by the bench's scenarios against a model of both lines. This covers the bit and word mapping of pixels and whether a word stored in the same cycle as a load reaches the new line. It also covers whether the old line survives as the back buffer, a read during a load, and the pointer wrapping after 128 steps.

// File: rtl/scanbuf_pkg.sv
package scanbuf_pkg;

  // Write-side command strobes for one cycle.
  typedef struct packed {
    logic store;
    logic step;
    logic load;
  } wr_cmd_t;

  localparam int unsigned NBANK = 2;

endpackage

// File: rtl/scanbuf_waddr.sv
module scanbuf_waddr
  import scanbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_cmd_t           cmd,
  output logic [ADDR_W-1:0] waddr
);

  logic [ADDR_W-1:0] waddr_d;
  logic              waddr_en;

  // Load wins over step; the store uses the pointer before the update.
  always_comb begin
    waddr_en = cmd.load | cmd.step;
    waddr_d  = waddr;
    if (cmd.load)      waddr_d = '0;
    else if (cmd.step) waddr_d = waddr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        waddr <= '0;
    else if (waddr_en) waddr <= waddr_d;
  end

  a_r5_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.step && !cmd.load) |=> waddr == ADDR_W'($past(waddr) + 1'b1));

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.step && !cmd.load) |=> $stable(waddr));

  a_r6_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.load |=> waddr == '0);

endmodule

// File: rtl/scanbuf_bank.sv
module scanbuf_bank #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned WORDS  = 128,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/scanbuf_rdport.sv
module scanbuf_rdport
  import scanbuf_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BIT_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NBANK-1:0][WORD_W-1:0] bank_word,
  input  logic                         act_sel,
  input  logic [BIT_W-1:0]             bit_idx,
  output logic                         pix
);

  logic [WORD_W-1:0] word_sel;
  logic              pix_d;

  always_comb begin
    word_sel = bank_word[act_sel];
    pix_d    = word_sel[bit_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix <= 1'b0;
    else        pix <= pix_d;
  end

endmodule

// File: rtl/scanline_dbuf.sv
module scanline_dbuf
  import scanbuf_pkg::*;
#(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned LINE_PIX = 2048
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic                        wr_store,
  input  logic                        wr_next,
  input  logic                        line_load,
  input  logic [$clog2(LINE_PIX)-1:0] pix_idx,
  output logic                        pix_out
);

  localparam int unsigned WORDS  = LINE_PIX / WORD_W;
  localparam int unsigned ADDR_W = $clog2(WORDS);
  localparam int unsigned BIT_W  = $clog2(WORD_W);
  localparam int unsigned IDX_W  = $clog2(LINE_PIX);

  // Reset: asserted at once, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core = rst_pipe[1];

  wr_cmd_t cmd;
  always_comb begin
    cmd.store = wr_store;
    cmd.step  = wr_next;
    cmd.load  = line_load;
  end

  logic [ADDR_W-1:0] waddr;

  scanbuf_waddr #(.ADDR_W(ADDR_W)) u_waddr (
    .clk   (clk),
    .rst_n (rst_core),
    .cmd   (cmd),
    .waddr (waddr)
  );

  // Bank role select: act_sel names the active bank.
  logic act_sel, act_sel_d;

  always_comb begin
    act_sel_d = act_sel;
    if (cmd.load) act_sel_d = ~act_sel;
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core)     act_sel <= 1'b0;
    else if (cmd.load) act_sel <= act_sel_d;
  end

  logic [ADDR_W-1:0]               raddr;
  logic [BIT_W-1:0]                rbit;
  logic [NBANK-1:0]                bank_we;
  logic [NBANK-1:0][WORD_W-1:0]    bank_word;

  assign raddr = pix_idx[IDX_W-1:BIT_W];
  assign rbit  = pix_idx[BIT_W-1:0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_we[b] = cmd.store && (act_sel != 1'(b));

    scanbuf_bank #(
      .WORD_W (WORD_W),
      .WORDS  (WORDS),
      .ADDR_W (ADDR_W)
    ) u_bank (
      .clk   (clk),
      .we    (bank_we[b]),
      .waddr (waddr),
      .wdata (wr_data),
      .raddr (raddr),
      .rdata (bank_word[b])
    );
  end

  scanbuf_rdport #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_core),
    .bank_word (bank_word),
    .act_sel   (act_sel),
    .bit_idx   (rbit),
    .pix       (pix_out)
  );

  // Cycles since reset release, saturating; it guards the $past window.
  logic [1:0] age, age_d;
  always_comb age_d = (age == 2'd3) ? age : age + 2'd1;
  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) age <= '0;
    else           age <= age_d;
  end

  a_r6_swap_on_load: assert property (@(posedge clk) disable iff (!rst_core)
    cmd.load |=> act_sel != $past(act_sel));

  a_r6_roles_hold: assert property (@(posedge clk) disable iff (!rst_core)
    !cmd.load |=> $stable(act_sel));

  a_r4_one_bank_written: assert property (@(posedge clk) disable iff (!rst_core)
    $onehot0(bank_we));

  a_r8_steady_output: assert property (@(posedge clk) disable iff (!rst_core)
    (age == 2'd3 && !$past(cmd.load) && pix_idx == $past(pix_idx))
      |=> pix_out == $past(pix_out));

  always_comb begin
    if (!rst_n) a_r1_reset_out: assert (pix_out == 1'b0 || $isunknown(pix_out));
  end

endmodule

// File: tb/sim_scanline_dbuf.sv
`timescale 1ns/1ps
module sim_scanline_dbuf;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] wr_data;
  logic        wr_store, wr_next, line_load;
  logic [10:0] pix_idx;
  logic        pix_out;

  always #5 clk = ~clk;

  scanline_dbuf u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_data   (wr_data),
    .wr_store  (wr_store),
    .wr_next   (wr_next),
    .line_load (line_load),
    .pix_idx   (pix_idx),
    .pix_out   (pix_out)
  );

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  // Requirement-level model of both lines.
  logic [15:0] m_act  [128];
  logic [15:0] m_back [128];
  int          m_addr = 0;

  localparam logic [10:0] RD_VEC [14] = '{
    11'd0, 11'd1, 11'd7, 11'd15, 11'd16, 11'd17, 11'd31, 11'd255,
    11'd1024, 11'd1031, 11'd1039, 11'd2032, 11'd2040, 11'd2047
  };

  function automatic logic [15:0] pat(input int w, input logic [15:0] s);
    return 16'(w * 40503) ^ s;
  endfunction

  function automatic logic m_pix(input logic [10:0] i);
    logic [15:0] w;
    w = m_act[i[10:4]];
    return w[i[3:0]];
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic op(input logic s, input logic i, input logic l, input logic [15:0] d);
    wr_store = s; wr_next = i; line_load = l; wr_data = d;
    @(posedge clk);
    if (s) m_back[m_addr] = d;
    if (l) begin
      for (int k = 0; k < 128; k++) begin
        logic [15:0] t;
        t = m_act[k]; m_act[k] = m_back[k]; m_back[k] = t;
      end
      m_addr = 0;
    end else if (i) m_addr = (m_addr + 1) % 128;
    @(negedge clk);
    wr_store = 0; wr_next = 0; line_load = 0;
  endtask

  task automatic rd(input logic [10:0] i, input string tag);
    pix_idx = i;
    @(posedge clk);
    @(negedge clk);
    check(tag, pix_out, m_pix(i));
  endtask

  task automatic rd_word(input int w, input string tag);
    for (int b = 0; b < 16; b++) rd(11'(w * 16 + b), tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_data = 0; wr_store = 0; wr_next = 0; line_load = 0; pix_idx = 0;
    #1;
    check("R1 output in reset", pix_out, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 output held in reset", pix_out, 1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // Fill both lines completely (pointer starts at 0, R1 / R5).
    for (int w = 0; w < 128; w++) op(1, 1, 0, pat(w, 16'h1234));
    op(0, 0, 1, 16'h0);
    for (int w = 0; w < 4; w++) begin
      op(1, 0, 0, pat(w, 16'hBEEF));
      op(0, 1, 0, 16'h0);
    end
    for (int w = 4; w < 128; w++) op(1, 1, 0, pat(w, 16'hBEEF));
    op(0, 0, 1, 16'h0);

    // R2: table of pixel indices walked against the model.
    for (int v = 0; v < 14; v++) rd(RD_VEC[v], "R2 pixel mapping");
    rd_word(3, "R5 separate store and step");

    // R4/R8: store into back buffer does not touch the active line.
    op(1, 0, 0, 16'hA5C3);
    rd_word(0, "R4 store hidden until load");

    // R3: one cycle of latency.
    rd(11'd0, "R3 latency setup");
    pix_idx = 11'd1;
    #1;
    check("R3 output holds before edge", pix_out, m_pix(11'd0));
    @(posedge clk); @(negedge clk);
    check("R3 output after one edge", pix_out, m_pix(11'd1));

    // R6: load swaps, old line kept as back buffer.
    op(0, 0, 1, 16'h0);
    rd_word(0, "R6 stored word now active");
    rd_word(5, "R6 rest of back line");
    op(0, 0, 1, 16'h0);
    rd_word(5, "R6 former line kept");
    op(0, 1, 1, 16'h0);              // load wins over step: pointer 0
    op(1, 0, 0, 16'h5A0F);
    op(0, 0, 1, 16'h0);
    rd_word(0, "R6 load resets pointer");

    // R7: store and load together.
    op(1, 0, 1, 16'hC0DE);
    rd_word(0, "R7 store with load");

    // R8: read during a load returns the old line.
    begin
      logic exp_old;
      pix_idx = 11'd3;
      exp_old = m_pix(11'd3);
      op(0, 0, 1, 16'h0);
      check("R8 read during load", pix_out, exp_old);
      rd(11'd3, "R8 read after load");
    end

    // R5: pointer wrap 127 -> 0.
    for (int k = 0; k < 127; k++) op(0, 1, 0, 16'h0);
    op(1, 1, 0, 16'h9182);
    op(1, 0, 0, 16'h6E7D);
    op(0, 0, 1, 16'h0);
    rd_word(127, "R5 last word written");
    rd_word(0, "R5 wrapped to word 0");

    // R1: asynchronous reset during operation.
    @(negedge clk);
    #2 rst_n = 0;
    #1;
    check("R1 async reset mid-run", pix_out, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule